// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Host Port

This block sits on an I/O-mapped expansion card and lets a host processor operate a three-wire serial EEPROM purely in software. Every host write strobe hands the block one command byte. Individual bits of that byte set the EEPROM serial clock and serial data-in lines. A dedicated code raises chip select. An internal feedback term then keeps it raised until a second, separate code arrives.

The block also samples the EEPROM data-out line on every write, so the host can read back one bit of a stored word per read strobe. While a read strobe is active, the block drives the shared card byte bus. At the same time it signals the neighbouring write-data latch to release that bus, so only one driver is ever active.

A host reads one 16-bit word in four steps. It sends the set code, then clocks a start bit, opcode and address out on the data-in bit. It then alternates clock-high and clock-low writes, each followed by a read. Finally it writes the end code to drop chip select.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: A synchronous active-high reset clears chip select, serial clock, serial data-in and the captured data-out bit. After reset, bus_drive and latch_off are low.
- R2: A write of byte 0x38 sets chip select, seen on the cycle after the write strobe.
- R3: While chip select is set, a write of any byte other than 0x05 keeps it set (for example 0x00, 0x10, 0x08, 0x18).
- R4: A write of 0x05 clears chip select on the next cycle. While chip select is clear, a write of any byte other than 0x38 leaves it clear.
- R5: On every write, the serial clock output takes bit 4 of the byte on the next cycle: 0x10 raises it and 0x00 lowers it.
- R6: On every write, the serial data-in output takes bit 3 of the byte on the next cycle (0x08 drives a one).
- R7: In a cycle without a write strobe, chip select, serial clock, serial data-in and the captured data-out bit keep their values.
- R8: Each write strobe captures the EEPROM data-out input into an internal bit. While rd_stb is high, bus_out carries that bit on bit 0 and zeros on bits 7 to 1. While rd_stb is low, bus_out is all zero.
- R9: bus_drive and latch_off are both high exactly in the cycles where rd_stb is high, and both low otherwise.
- R10: Sixteen clock-high/clock-low/read sequences return the sixteen data-out bits presented by the EEPROM, most significant first, one per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host I/O write strobe, one cycle per byte |
| rd_stb | input | 1 | Host I/O read strobe |
| wr_data | input | 8 | Byte written by the host |
| ee_do | input | 1 | EEPROM serial data output |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data input |
| bus_out | output | 8 | Byte this block places on the shared bus |
| bus_drive | output | 1 | High while this block drives the shared bus |
| latch_off | output | 1 | High to tell the write-data latch to release the bus |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, set code 0x38, end code 0x05, clock on bit 4, data-in on bit 3 and the read bit on bit 0. These values make the chip-select hold term and its release reachable with the same byte patterns a host uses during a real word read. The bench walks a complete 16-bit readout of the word 0x42D0. Along the way it exercises writes before chip select is raised, a read coinciding with a write, and a reset that arrives in the middle of a transfer.

// File: rtl/eebb_pkg.sv
package eebb_pkg;

    // Registered control state of the port
    typedef struct packed {
        logic sk;
        logic di;
        logic dout;
    } line_state_t;

endpackage

// File: rtl/eebb_cmd_decode.sv
module eebb_cmd_decode #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SET_CODE = 8'h38,
    parameter logic [7:0]  END_CODE = 8'h05,
    parameter int          SK_BIT   = 4,
    parameter int          DI_BIT   = 3
) (
    input  logic [DATA_W-1:0] byte_i,
    output logic              is_set,
    output logic              is_end,
    output logic              sk_bit,
    output logic              di_bit
);
    localparam logic [DATA_W-1:0] SET_W = DATA_W'(SET_CODE);
    localparam logic [DATA_W-1:0] END_W = DATA_W'(END_CODE);

    always_comb begin
        is_set = (byte_i == SET_W);
        is_end = (byte_i == END_W);
        sk_bit = byte_i[SK_BIT];
        di_bit = byte_i[DI_BIT];
    end
endmodule

// File: rtl/eebb_cs_hold.sv
module eebb_cs_hold (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic is_set,
    input  logic is_end,
    output logic cs_q
);
    logic cs_d;

    // Set by one code, then held through its own output until the end code
    always_comb begin
        cs_d = cs_q;
        if (wr) begin
            cs_d = is_set | (cs_q & ~is_end);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b0;
        else     cs_q <= cs_d;
    end

    a_r1_cs_reset: assert property (@(posedge clk) rst |=> !cs_q);
    a_r2_set_code: assert property (@(posedge clk) disable iff (rst)
        (wr && is_set) |=> cs_q);
    a_r3_hold_term: assert property (@(posedge clk) disable iff (rst)
        (wr && cs_q && !is_end) |=> cs_q);
    a_r4_end_code: assert property (@(posedge clk) disable iff (rst)
        (wr && is_end && !is_set) |=> !cs_q);
    a_r7_cs_idle: assert property (@(posedge clk) disable iff (rst)
        (!wr) |=> $stable(cs_q));
endmodule

// File: rtl/eebb_bus_arb.sv
module eebb_bus_arb #(
    parameter int DATA_W = 8,
    parameter int DO_BIT = 0
) (
    input  logic              rd,
    input  logic              dout,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic              latch_off
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == DO_BIT) begin : g_do
            assign bus_out[i] = rd & dout;
        end else begin : g_zero
            assign bus_out[i] = 1'b0;
        end
    end

    always_comb begin
        bus_drive = rd;
        latch_off = rd;
    end

    always_comb begin
        a_r9_single_driver: assert (!(bus_drive && !latch_off));
        a_r8_idle_zero: assert (rd || bus_out == '0);
    end
endmodule

// File: rtl/eeprom_bitbang_port.sv
module eeprom_bitbang_port #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SET_CODE = 8'h38,
    parameter logic [7:0]  END_CODE = 8'h05,
    parameter int          SK_BIT   = 4,
    parameter int          DI_BIT   = 3,
    parameter int          DO_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic              latch_off
);
    import eebb_pkg::*;

    logic        is_set, is_end, sk_bit, di_bit;
    line_state_t st_d, st_q;

    eebb_cmd_decode #(
        .DATA_W  (DATA_W),
        .SET_CODE(SET_CODE),
        .END_CODE(END_CODE),
        .SK_BIT  (SK_BIT),
        .DI_BIT  (DI_BIT)
    ) u_dec (
        .byte_i(wr_data),
        .is_set(is_set),
        .is_end(is_end),
        .sk_bit(sk_bit),
        .di_bit(di_bit)
    );

    eebb_cs_hold u_cs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_stb),
        .is_set(is_set),
        .is_end(is_end),
        .cs_q  (ee_cs)
    );

    // Clock, data-in and the sampled data-out all move on the write strobe
    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.sk   = sk_bit;
            st_d.di   = di_bit;
            st_d.dout = ee_do;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ee_sk = st_q.sk;
    assign ee_di = st_q.di;

    eebb_bus_arb #(
        .DATA_W(DATA_W),
        .DO_BIT(DO_BIT)
    ) u_arb (
        .rd       (rd_stb),
        .dout     (st_q.dout),
        .bus_out  (bus_out),
        .bus_drive(bus_drive),
        .latch_off(latch_off)
    );

    a_r1_lines_reset: assert property (@(posedge clk)
        rst |=> (!ee_sk && !ee_di && !st_q.dout));
    a_r5_sk_follows: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (ee_sk == $past(wr_data[SK_BIT])));
    a_r6_di_follows: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (ee_di == $past(wr_data[DI_BIT])));
    a_r8_do_capture: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (st_q.dout == $past(ee_do)));
    a_r7_lines_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(ee_sk) && $stable(ee_di) && $stable(st_q.dout)));
    a_r9_read_drive: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> (bus_drive && latch_off));
endmodule

// File: tb/eeprom_bitbang_port_tb.sv
module eeprom_bitbang_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ee_do = 1'b0;
    logic       ee_cs, ee_sk, ee_di, bus_drive, latch_off;
    logic [7:0] bus_out;

    int total = 0;
    int bad = 0;

    // Behavioural reference state
    int m_cs = 0, m_sk = 0, m_di = 0, m_do = 0;

    always #2 clk = ~clk;

    eeprom_bitbang_port u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wr_data(wr_data), .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .bus_out(bus_out), .bus_drive(bus_drive),
        .latch_off(latch_off)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Reference model advances on each edge from the stable inputs
    always @(posedge clk) begin
        if (rst) begin
            m_cs = 0; m_sk = 0; m_di = 0; m_do = 0;
        end else if (wr_stb) begin
            m_cs = (wr_data == 8'h38 || (m_cs == 1 && wr_data != 8'h05)) ? 1 : 0;
            m_sk = int'(wr_data[4]);
            m_di = int'(wr_data[3]);
            m_do = int'(ee_do);
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        chk("R3 cs", int'(ee_cs), m_cs);
        chk("R5 sk", int'(ee_sk), m_sk);
        chk("R6 di", int'(ee_di), m_di);
        chk("R8 bus", int'(bus_out), rd_stb ? m_do : 0);
        chk("R9 drive", int'(bus_drive), int'(rd_stb));
        chk("R9 latch_off", int'(latch_off), int'(rd_stb));
    end

    task automatic wr(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_stb = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd_bit(input int exp);
        rd_stb = 1'b1;
        @(negedge clk);
        chk("R10 read bit", int'(bus_out), exp);
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] word;
        word = 16'h42D0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 cs", int'(ee_cs), 0);
        chk("R1 sk", int'(ee_sk), 0);
        chk("R1 drive", int'(bus_drive), 0);
        @(posedge clk); #1;

        // R4: writes while cs clear do not set it
        wr(8'h10); wr(8'h08); wr(8'h05);
        @(negedge clk); chk("R4 stays clear", int'(ee_cs), 0);
        @(posedge clk); #1;

        // R2: set code
        wr(8'h38);
        @(negedge clk);
        chk("R2 cs set", int'(ee_cs), 1);
        chk("R6 di from 0x38", int'(ee_di), 1);
        @(posedge clk); #1;

        // R3: hold across other codes
        wr(8'h00); wr(8'h10); wr(8'h08); wr(8'h18); wr(8'h00);
        @(negedge clk); chk("R3 cs held", int'(ee_cs), 1);
        @(posedge clk); #1;

        // R7: idle cycles
        wr(8'h18);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R7 sk kept", int'(ee_sk), 1);
        chk("R7 di kept", int'(ee_di), 1);
        @(posedge clk); #1;

        // R10: sixteen-bit readout, MSB first
        for (int i = 15; i >= 0; i--) begin
            ee_do = word[i];
            wr(8'h10);
            wr(8'h00);
            ee_do = ~word[i];
            rd_bit(int'(word[i]));
        end

        // R8: read and write in the same cycle
        ee_do = 1'b1;
        rd_stb = 1'b1;
        wr(8'h10);
        rd_stb = 1'b0;
        rd_bit(1);

        // R4: end code clears, then stays clear
        wr(8'h05);
        @(negedge clk); chk("R4 cs cleared", int'(ee_cs), 0);
        @(posedge clk); #1;
        wr(8'h18);
        @(negedge clk); chk("R4 no reassert", int'(ee_cs), 0);
        @(posedge clk); #1;

        // R1: reset mid-transfer
        wr(8'h38);
        ee_do = 1'b1; wr(8'h18);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs after reset", int'(ee_cs), 0);
        chk("R1 di after reset", int'(ee_di), 0);
        @(posedge clk); #1;
        rd_bit(0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule